// File: doc/BRIEF.md
# DMA Interrupt Status and Clear Unit

This block is the shared interrupt bank of a multi-channel DMA controller. Each channel engine pulses a terminal-count or an error strobe, and the bank keeps a sticky per-channel flag for each. Software reads these flags through a small word-addressed register window. It can see the raw flags, the flags filtered by per-channel enables, and the union of both masked sets. It removes flags by writing ones to one of two write-one-to-clear words.

The per-channel enables are not registers of their own. They are decoded from each channel's configuration word, which the channel engines own and present on a flat input bus. The same configuration words also yield a bitmap of the channels that are currently enabled. A single registered, level-sensitive interrupt line is high while any masked flag is set.

Top module: `dma_irq_status_unit`

## Requirements
- R1: A one-cycle pulse on `tc_set[i]` or `err_set[i]` sets that channel's raw flag at the next clock edge. The flag then holds until it is cleared or reset. Word 5 reads the raw terminal-count flags and word 6 reads the raw error flags, with channel i at bit i.
- R2: Writing word 2 clears every terminal-count flag whose bit is 1 in `wdata`. Flags whose bit is 0 are left unchanged, and `wdata` bits at or above NUM_CH are ignored.
- R3: Writing word 4 clears every error flag whose bit is 1 in `wdata`. Flags whose bit is 0 are left unchanged.
- R4: When a set pulse and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R5: Word 1 reads the terminal-count flags ANDed with bit 15 of each channel's configuration word. Word 3 reads the error flags ANDed with bit 14 of each channel's configuration word. Channel i's configuration word is `ch_cfg[32*i +: 32]`.
- R6: Word 0 reads the bitwise OR of the masked terminal-count status and the masked error status.
- R7: Word 7 reads a bitmap with bit i set when bit 0 of channel i's configuration word is set.
- R8: Words 2, 4 and 8 to 15 read as zero. A write to any word other than 2 or 4 leaves every flag unchanged.
- R9: Every read-data bit at or above NUM_CH is zero.
- R10: `irq` is high exactly when some masked terminal-count or masked error flag is set, one clock after the flags and configuration inputs settle.
- R11: A synchronous active-high `rst` clears all flags, `irq` and `rdata`.
- R12: `rdata` carries the addressed word on the clock edge after `rd_en` is sampled high, and is zero after any edge where `rd_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tc_set | input | NUM_CH | Per-channel terminal-count set pulses |
| err_set | input | NUM_CH | Per-channel error set pulses |
| ch_cfg | input | NUM_CH*32 | Flat channel configuration words, channel i at bits 32*i+31..32*i |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench hits a clear and a set on the same flag in one cycle. A design that lets the clear win would drop a completion that arrives while software acknowledges an older one. It writes all-ones to clear words and to read-only words, and reads the unmapped words. A decoder that aliases addresses, or that keeps high `wdata` bits, then shows corrupted flags or non-zero reads. It sets a flag on a channel whose mask is off, so that `irq` stays low, and then turns the mask on through the configuration input. A design that latched the masks, or that OR'd in raw flags, would show the wrong interrupt level in one of these two phases. It also checks that `rdata` returns to zero after a read, and that a reset in the middle of a run clears all the sticky state.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int CFG_W        = 32;
  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_ERRM_BIT = 14;
  localparam int CFG_TCM_BIT  = 15;

  localparam int WORD_ANY_MASKED = 0;
  localparam int WORD_TC_MASKED  = 1;
  localparam int WORD_TC_CLEAR   = 2;
  localparam int WORD_ERR_MASKED = 3;
  localparam int WORD_ERR_CLEAR  = 4;
  localparam int WORD_TC_RAW     = 5;
  localparam int WORD_ERR_RAW    = 6;
  localparam int WORD_ENABLED    = 7;
endpackage

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flags_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i[i]) flags_o[i] <= 1'b0;
    end

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flags_o[i]);
    // Covers R2 and R3: a clear with no set empties the flag
    assert_clear_takes_R2: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
    assert_flag_holds_R1: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_i[i]) |=> $stable(flags_o[i]));
  end
endmodule

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH*CFG_W-1:0] cfg_i,
  output logic [NUM_CH-1:0]       tc_mask_o,
  output logic [NUM_CH-1:0]       err_mask_o,
  output logic [NUM_CH-1:0]       enabled_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign tc_mask_o[i]  = cfg_i[i*CFG_W + CFG_TCM_BIT];
    assign err_mask_o[i] = cfg_i[i*CFG_W + CFG_ERRM_BIT];
    assign enabled_o[i]  = cfg_i[i*CFG_W + CFG_EN_BIT];
  end
endmodule

// File: rtl/dma_status_regs.sv
module dma_status_regs
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM_CH-1:0] tc_flags,
  input  logic [NUM_CH-1:0] err_flags,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_mask,
  input  logic [NUM_CH-1:0] enabled,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_CH-1:0] tc_m, err_m, sel;
  logic [DATA_W-1:0] rd_mux;

  assign tc_m  = tc_flags & tc_mask;
  assign err_m = err_flags & err_mask;

  always_comb begin
    case (addr)
      ADDR_W'(WORD_ANY_MASKED): sel = tc_m | err_m;
      ADDR_W'(WORD_TC_MASKED):  sel = tc_m;
      ADDR_W'(WORD_ERR_MASKED): sel = err_m;
      ADDR_W'(WORD_TC_RAW):     sel = tc_flags;
      ADDR_W'(WORD_ERR_RAW):    sel = err_flags;
      ADDR_W'(WORD_ENABLED):    sel = enabled;
      default:                  sel = '0;
    endcase
    rd_mux = '0;
    rd_mux[NUM_CH-1:0] = sel;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > ADDR_W'(WORD_ENABLED)) |=> (rdata == '0));

  if (NUM_CH < DATA_W) begin : g_upper
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
      rdata[DATA_W-1:NUM_CH] == '0);
  end
endmodule

// File: rtl/dma_irq_status_unit.sv
module dma_irq_status_unit
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       tc_set,
  input  logic [NUM_CH-1:0]       err_set,
  input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic                    irq
);
  logic [NUM_CH-1:0] tc_clr, err_clr;
  logic [NUM_CH-1:0] tc_flags, err_flags;
  logic [NUM_CH-1:0] tc_mask, err_mask, enabled;

  assign tc_clr  = (wr_en && addr == ADDR_W'(WORD_TC_CLEAR))  ? wdata[NUM_CH-1:0] : '0;
  assign err_clr = (wr_en && addr == ADDR_W'(WORD_ERR_CLEAR)) ? wdata[NUM_CH-1:0] : '0;

  dma_flag_bank #(.NUM_CH(NUM_CH)) u_tc_bank (
    .clk(clk), .rst(rst), .set_i(tc_set), .clr_i(tc_clr), .flags_o(tc_flags));

  dma_flag_bank #(.NUM_CH(NUM_CH)) u_err_bank (
    .clk(clk), .rst(rst), .set_i(err_set), .clr_i(err_clr), .flags_o(err_flags));

  dma_cfg_decode #(.NUM_CH(NUM_CH)) u_cfg (
    .cfg_i(ch_cfg), .tc_mask_o(tc_mask), .err_mask_o(err_mask), .enabled_o(enabled));

  dma_status_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .tc_flags(tc_flags), .err_flags(err_flags),
    .tc_mask(tc_mask), .err_mask(err_mask), .enabled(enabled),
    .rdata(rdata));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |{tc_flags & tc_mask, err_flags & err_mask};
  end

  // An interrupt edge always follows some flag that was already set
  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|{tc_flags, err_flags}));
  assert_irq_drops_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(tc_flags) == '0 && $past(err_flags) == '0) |-> !irq);
endmodule

// File: tb/sim_dma_irq_status_unit.sv
module sim_dma_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int AW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] tc_set = '0, err_set = '0;
  logic [NCH*32-1:0] ch_cfg = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic pend_q = 1'b0;
  logic [NCH-1:0] m_tc = '0, m_err = '0;
  logic [31:0] m_cfg [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status_unit #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .tc_set(tc_set), .err_set(err_set), .ch_cfg(ch_cfg),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  function automatic logic [DW-1:0] model_read(int a);
    logic [NCH-1:0] tm, em, en, v;
    for (int i = 0; i < NCH; i++) begin
      tm[i] = m_cfg[i][15]; em[i] = m_cfg[i][14]; en[i] = m_cfg[i][0];
    end
    case (a)
      0: v = (m_tc & tm) | (m_err & em);
      1: v = m_tc & tm;
      3: v = m_err & em;
      5: v = m_tc;
      6: v = m_err;
      7: v = en;
      default: v = '0;
    endcase
    return {{(DW-NCH){1'b0}}, v};
  endfunction

  function automatic logic model_irq();
    return model_read(0) != '0;
  endfunction

  task automatic apply_cfg();
    for (int i = 0; i < NCH; i++) ch_cfg[i*32 +: 32] = m_cfg[i];
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      tc_set = '0; err_set = '0; rd_en = 1'b0; wr_en = 1'b0;
    end
  endtask

  // One cycle: optional set pulses plus optional register write
  task automatic cycle(logic [NCH-1:0] ts, logic [NCH-1:0] es,
                       logic we, int wa, logic [DW-1:0] wd);
    logic [NCH-1:0] tcl, ecl;
    @(negedge clk);
    tc_set = ts; err_set = es; rd_en = 1'b0;
    wr_en = we; addr = AW'(wa); wdata = wd;
    tcl = (we && wa == 2) ? wd[NCH-1:0] : '0;
    ecl = (we && wa == 4) ? wd[NCH-1:0] : '0;
    m_tc  = (m_tc & ~tcl) | ts;
    m_err = (m_err & ~ecl) | es;
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk);
    tc_set = '0; err_set = '0; wr_en = 1'b0;
    rd_en = 1'b1; addr = AW'(a);
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic chk_irq(string tag);
    idle(2);
    chk(tag, {31'b0, irq}, {31'b0, model_irq()});
  endtask

  // Monitor: pops one expected word per read, one edge after the strobe
  always @(posedge clk) pend_q <= rd_en;
  always @(negedge clk) begin
    if (pend_q) begin
      if (exp_q.size() == 0) begin
        chk("R12 unexpected read data", rdata, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) m_cfg[i] = '0;
    m_cfg[0] = 32'h0000_8001;
    m_cfg[1] = 32'h0000_4000;
    m_cfg[2] = 32'h0000_C001;
    apply_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R11: reset state
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);
    chk("R11 rdata after reset", rdata, '0);
    rd(5, "R11 raw tc after reset");
    rd(6, "R11 raw err after reset");
    // R1, R5, R6, R10
    cycle(8'h05, 8'h00, 1'b0, 0, '0);
    rd(5, "R1 raw tc after set");
    rd(1, "R5 masked tc");
    rd(0, "R6 combined");
    chk_irq("R10 irq on masked tc");
    cycle(8'h08, 8'h00, 1'b0, 0, '0);
    rd(5, "R1 raw tc accumulates");
    rd(1, "R5 masked tc ignores unmasked ch3");
    cycle(8'h00, 8'h12, 1'b0, 0, '0);
    rd(6, "R1 raw err");
    rd(3, "R5 masked err");
    rd(0, "R6 combined tc and err");
    rd(7, "R7 enabled bitmap");
    // R12: read data returns to zero
    idle(2);
    chk("R12 rdata idle zero", rdata, '0);
    // R2: clear with high garbage bits
    cycle(8'h00, 8'h00, 1'b1, 2, 32'hFFFF_FF01);
    rd(5, "R2 tc clear selected bits");
    rd(6, "R2 err untouched by tc clear");
    // R3
    cycle(8'h00, 8'h00, 1'b1, 4, 32'h0000_0002);
    rd(6, "R3 err clear");
    rd(5, "R3 tc untouched by err clear");
    // R4: set and clear same flag same cycle
    cycle(8'h02, 8'h00, 1'b1, 2, 32'h0000_0002);
    rd(5, "R4 set wins over clear");
    cycle(8'h00, 8'h10, 1'b1, 4, 32'h0000_0010);
    rd(6, "R4 err set wins");
    // R8: writes elsewhere, unmapped reads
    cycle(8'h00, 8'h00, 1'b1, 5, '1);
    cycle(8'h00, 8'h00, 1'b1, 7, '1);
    cycle(8'h00, 8'h00, 1'b1, 13, '1);
    rd(5, "R8 tc unchanged by other writes");
    rd(6, "R8 err unchanged by other writes");
    rd(2, "R8 clear word reads zero");
    rd(4, "R8 clear word reads zero");
    rd(9, "R8 unmapped read");
    rd(15, "R8 unmapped read top");
    // R10: everything cleared drops irq
    cycle(8'h00, 8'h00, 1'b1, 2, '1);
    cycle(8'h00, 8'h00, 1'b1, 4, '1);
    chk_irq("R10 irq low after full clear");
    // R10: unmasked flag keeps irq low, then enabling mask raises it
    cycle(8'h08, 8'h00, 1'b0, 0, '0);
    chk_irq("R10 irq low for unmasked flag");
    @(negedge clk);
    m_cfg[3] = 32'h0000_8000;
    apply_cfg();
    chk_irq("R10 irq follows mask change");
    rd(1, "R5 masked tc after cfg change");
    // R9: all channels set, upper bits zero
    cycle(8'hFF, 8'hFF, 1'b0, 0, '0);
    rd(5, "R9 raw tc full width");
    rd(6, "R9 raw err full width");
    // R11: mid-run reset
    idle(2);
    @(negedge clk);
    rst = 1'b1;
    m_tc = '0; m_err = '0;
    @(negedge clk);
    rst = 1'b0;
    rd(5, "R11 tc cleared by reset");
    rd(6, "R11 err cleared by reset");
    idle(1);
    chk("R11 irq cleared by reset", {31'b0, irq}, 32'h0);
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule